// File: doc/BRIEF.md
# Privilege-Gated Thread Identifier Register

This block holds one 64-bit thread identifier that privileged software sets and that unprivileged software may only read. Each cycle it takes one decoded system-register access (the five encoding fields, a read/write select and write data) together with the current exception level and a set of configuration flags. For each access it decides, in the same cycle, whether the access completes, is undefined, or traps to the hypervisor level. Completed writes update the stored value at the next clock edge.

Reads and writes follow separate rules. Reads are permitted from the lowest level and can be trapped by a read-trap bit. Writes from the lowest level are always undefined, and writes from the kernel level can be trapped by a separate write-trap bit. Both trap bits only take effect when the hypervisor level is enabled and fine-grained trapping is implemented, and when the highest level either is absent or has enabled fine-grained trapping. The read trap at the lowest level is also suppressed when that level runs in host mode. The low 32 bits of the register are always visible on a separate narrow alias output.

Top module: `tid_sysreg_unit`

## Requirements
- R1: An access is recognised only when acc_valid is 1 and op0=2'b11, op1=3'b011, CRn=4'b1101, CRm=4'b0000, op2=3'b011; otherwise acc_done, undef and trap_valid stay 0, rdata is 0 and the stored value is unchanged.
- R2: When cfg_feat64 is 0, every recognised access is undefined, at any exception level.
- R3: A read at EL0 (cur_el=0) traps when cfg_el2_en, cfg_fgt_impl and cfg_rd_trap are 1, cfg_el0_host is 0, and either cfg_el3_present is 0 or cfg_el3_fgt_en is 1; otherwise it completes.
- R4: A read at EL1 (cur_el=1) traps under the R3 conditions with cfg_el0_host ignored; otherwise it completes.
- R5: A write (acc_write=1) at EL0 is always undefined.
- R6: A write at EL1 traps when cfg_el2_en, cfg_fgt_impl and cfg_wr_trap are 1 and either cfg_el3_present is 0 or cfg_el3_fgt_en is 1; otherwise it completes.
- R7: Reads and writes at EL2 (cur_el=2) and EL3 (cur_el=3) always complete, regardless of the trap and host flags.
- R8: A trap reports trap_el=2'd2 and trap_class=6'h18.
- R9: A trapped or undefined access leaves the stored value unchanged and drives rdata to 0.
- R10: The register resets to 0; a completed write stores all 64 bits at the clock edge so a read in the next cycle returns them, and a completed read drives the full 64-bit value on rdata (rdata is 0 for writes).
- R11: alias_rdata always equals bits [31:0] of the stored value.
- R12: For a recognised access exactly one of acc_done, undef and trap_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level 0..3 |
| cfg_feat64 | input | 1 | 64-bit execution state implemented |
| cfg_el2_en | input | 1 | Hypervisor level enabled |
| cfg_el0_host | input | 1 | Lowest level runs in host mode |
| cfg_fgt_impl | input | 1 | Fine-grained traps implemented |
| cfg_el3_present | input | 1 | Highest level implemented |
| cfg_el3_fgt_en | input | 1 | Highest level enables fine-grained traps |
| cfg_rd_trap | input | 1 | Read-trap bit for this register |
| cfg_wr_trap | input | 1 | Write-trap bit for this register |
| acc_done | output | 1 | Access completes |
| rdata | output | 64 | Read data of a completed read, else 0 |
| undef | output | 1 | Access is undefined |
| trap_valid | output | 1 | Access traps |
| trap_el | output | 2 | Trap target level |
| trap_class | output | 6 | Trap syndrome class |
| alias_rdata | output | 32 | 32-bit alias view of the low half |

## Verification
A corrupted stored value shows on alias_rdata within one cycle of the edge that corrupted it, and on rdata at the next completed read, so the bench compares the alias every cycle and reads back after writes. A write that wrongly lands after a trap or undefined outcome shows the same way. Mistakes in the trap qualification show immediately in the same cycle as a wrong outcome flag, so the random sweep toggles every configuration flag independently at every level.

// File: rtl/tid_sysreg_pkg.sv
package tid_sysreg_pkg;
    localparam int TID_W      = 64;
    localparam int ALIAS_W    = 32;
    localparam int EL_W       = 2;
    localparam int CLASS_W    = 6;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_DONE  = 2'd1,
        OUT_UNDEF = 2'd2,
        OUT_TRAP  = 2'd3
    } outcome_e;

    typedef struct packed {
        logic [TID_W-1:0] value;
    } tid_state_t;
endpackage

// File: rtl/tid_encoding_match.sv
module tid_encoding_match #(
    parameter logic [1:0] ENC_OP0 = 2'b11,
    parameter logic [2:0] ENC_OP1 = 3'b011,
    parameter logic [3:0] ENC_CRN = 4'b1101,
    parameter logic [3:0] ENC_CRM = 4'b0000,
    parameter logic [2:0] ENC_OP2 = 3'b011
) (
    input  logic       valid,
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    always_comb begin
        hit = valid
            && (op0 == ENC_OP0)
            && (op1 == ENC_OP1)
            && (crn == ENC_CRN)
            && (crm == ENC_CRM)
            && (op2 == ENC_OP2);
    end
endmodule

// File: rtl/tid_access_policy.sv
module tid_access_policy
    import tid_sysreg_pkg::*;
#(
    parameter int EL_BITS = EL_W
) (
    input  logic               hit,
    input  logic               is_write,
    input  logic [EL_BITS-1:0] el,
    input  logic               feat64,
    input  logic               el2_en,
    input  logic               el0_host,
    input  logic               fgt_impl,
    input  logic               el3_present,
    input  logic               el3_fgt_en,
    input  logic               rd_trap,
    input  logic               wr_trap,
    output outcome_e           outcome
);
    logic fine_trap_live;

    always_comb begin
        fine_trap_live = el2_en && fgt_impl && (!el3_present || el3_fgt_en);
        outcome = OUT_NONE;
        if (hit) begin
            if (!feat64) begin
                outcome = OUT_UNDEF;
            end else begin
                case (el)
                    EL_BITS'(0): begin
                        if (is_write)
                            outcome = OUT_UNDEF;
                        else if (fine_trap_live && !el0_host && rd_trap)
                            outcome = OUT_TRAP;
                        else
                            outcome = OUT_DONE;
                    end
                    EL_BITS'(1): begin
                        if (fine_trap_live && (is_write ? wr_trap : rd_trap))
                            outcome = OUT_TRAP;
                        else
                            outcome = OUT_DONE;
                    end
                    default: outcome = OUT_DONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/tid_value_store.sv
module tid_value_store
    import tid_sysreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_data,
    output logic [TID_W-1:0] value
);
    tid_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en)
            state_d.value = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign value = state_q.value;

    // R9: without a write enable the stored value holds
    a_r9_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));

    // R10: an enabled write lands on the next edge
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data)));
endmodule

// File: rtl/tid_sysreg_unit.sv
module tid_sysreg_unit
    import tid_sysreg_pkg::*;
#(
    parameter int                 DATA_W     = TID_W,
    parameter int                 VIEW_W     = ALIAS_W,
    parameter logic [EL_W-1:0]    TRAP_LEVEL = 2'd2,
    parameter logic [CLASS_W-1:0] TRAP_EC    = 6'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [1:0]         acc_op0,
    input  logic [2:0]         acc_op1,
    input  logic [3:0]         acc_crn,
    input  logic [3:0]         acc_crm,
    input  logic [2:0]         acc_op2,
    input  logic               acc_write,
    input  logic [DATA_W-1:0]  acc_wdata,
    input  logic [EL_W-1:0]    cur_el,
    input  logic               cfg_feat64,
    input  logic               cfg_el2_en,
    input  logic               cfg_el0_host,
    input  logic               cfg_fgt_impl,
    input  logic               cfg_el3_present,
    input  logic               cfg_el3_fgt_en,
    input  logic               cfg_rd_trap,
    input  logic               cfg_wr_trap,
    output logic               acc_done,
    output logic [DATA_W-1:0]  rdata,
    output logic               undef,
    output logic               trap_valid,
    output logic [EL_W-1:0]    trap_el,
    output logic [CLASS_W-1:0] trap_class,
    output logic [VIEW_W-1:0]  alias_rdata
);
    logic              enc_hit;
    outcome_e          outcome;
    logic              store_en;
    logic [DATA_W-1:0] stored;

    tid_encoding_match u_match (
        .valid (acc_valid),
        .op0   (acc_op0),
        .op1   (acc_op1),
        .crn   (acc_crn),
        .crm   (acc_crm),
        .op2   (acc_op2),
        .hit   (enc_hit)
    );

    tid_access_policy #(.EL_BITS(EL_W)) u_policy (
        .hit         (enc_hit),
        .is_write    (acc_write),
        .el          (cur_el),
        .feat64      (cfg_feat64),
        .el2_en      (cfg_el2_en),
        .el0_host    (cfg_el0_host),
        .fgt_impl    (cfg_fgt_impl),
        .el3_present (cfg_el3_present),
        .el3_fgt_en  (cfg_el3_fgt_en),
        .rd_trap     (cfg_rd_trap),
        .wr_trap     (cfg_wr_trap),
        .outcome     (outcome)
    );

    assign store_en = (outcome == OUT_DONE) && acc_write;

    tid_value_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_data (acc_wdata),
        .value   (stored)
    );

    always_comb begin
        acc_done   = (outcome == OUT_DONE);
        undef      = (outcome == OUT_UNDEF);
        trap_valid = (outcome == OUT_TRAP);
        trap_el    = trap_valid ? TRAP_LEVEL : '0;
        trap_class = trap_valid ? TRAP_EC : '0;
        rdata      = (acc_done && !acc_write) ? stored : '0;
    end

    assign alias_rdata = stored[VIEW_W-1:0];

    // R12: at most one outcome flag
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_done, undef, trap_valid}));

    // R12: a recognised access always yields an outcome
    a_r12_some_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        enc_hit |-> (acc_done || undef || trap_valid));

    // R1: unrecognised access is quiet
    a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_hit |-> !(acc_done || undef || trap_valid));

    // R5: write at the lowest level never completes or traps
    a_r5_el0_write_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_hit && acc_write && cur_el == '0) |-> undef);

    // R8: traps only arise at the two lowest levels
    a_r8_trap_source: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (cur_el < EL_W'(2)) && cfg_feat64 && cfg_el2_en);

    // R9: failed access drives zero read data and leaves the alias alone
    a_r9_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (undef || trap_valid) |-> (rdata == '0));
    a_r9_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (undef || trap_valid) |=> $stable(alias_rdata));
endmodule

// File: tb/tid_sysreg_unit_test.sv
module tid_sysreg_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op0 = '0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crn = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic        acc_write = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  cur_el = '0;
    logic        cfg_feat64 = 1'b1, cfg_el2_en = 1'b0, cfg_el0_host = 1'b0;
    logic        cfg_fgt_impl = 1'b0, cfg_el3_present = 1'b0, cfg_el3_fgt_en = 1'b0;
    logic        cfg_rd_trap = 1'b0, cfg_wr_trap = 1'b0;
    logic        acc_done, undef, trap_valid;
    logic [63:0] rdata;
    logic [1:0]  trap_el;
    logic [5:0]  trap_class;
    logic [31:0] alias_rdata;

    int tests = 0;
    int fails = 0;
    logic [63:0] model = '0;

    always #4 clk = ~clk;

    tid_sysreg_unit uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
        .acc_crm(acc_crm), .acc_op2(acc_op2), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .cur_el(cur_el), .cfg_feat64(cfg_feat64),
        .cfg_el2_en(cfg_el2_en), .cfg_el0_host(cfg_el0_host),
        .cfg_fgt_impl(cfg_fgt_impl), .cfg_el3_present(cfg_el3_present),
        .cfg_el3_fgt_en(cfg_el3_fgt_en), .cfg_rd_trap(cfg_rd_trap),
        .cfg_wr_trap(cfg_wr_trap), .acc_done(acc_done), .rdata(rdata),
        .undef(undef), .trap_valid(trap_valid), .trap_el(trap_el),
        .trap_class(trap_class), .alias_rdata(alias_rdata)
    );

    // expected outcome: 0 none, 1 done, 2 undef, 3 trap
    function automatic int expect_outcome();
        logic hit, gate;
        hit = acc_valid && acc_op0 == 2'b11 && acc_op1 == 3'b011 &&
              acc_crn == 4'b1101 && acc_crm == 4'b0000 && acc_op2 == 3'b011;
        gate = cfg_el2_en && cfg_fgt_impl && (!cfg_el3_present || cfg_el3_fgt_en);
        if (!hit) return 0;                                   // R1
        if (!cfg_feat64) return 2;                            // R2
        if (cur_el >= 2) return 1;                            // R7
        if (cur_el == 0) begin
            if (acc_write) return 2;                          // R5
            return (gate && !cfg_el0_host && cfg_rd_trap) ? 3 : 1;  // R3
        end
        if (acc_write) return (gate && cfg_wr_trap) ? 3 : 1;  // R6
        return (gate && cfg_rd_trap) ? 3 : 1;                 // R4
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_enc(input bit good);
        acc_op0 = 2'b11; acc_op1 = 3'b011; acc_crn = 4'b1101;
        acc_crm = 4'b0000; acc_op2 = 3'b011;
        if (!good) begin
            case ($urandom_range(0, 4))
                0: acc_op0 = 2'b10;
                1: acc_op1 = 3'b010;
                2: acc_crn = 4'b1100;
                3: acc_crm = 4'b0001;
                default: acc_op2 = 3'b010;
            endcase
        end
    endtask

    // apply current inputs for one cycle and check everything
    task automatic run_access(input string req);
        int exp;
        logic [3:0] exp_flags, act_flags;
        logic [63:0] exp_rd;
        #1;
        exp = expect_outcome();
        exp_flags = {exp == 0, exp == 1, exp == 2, exp == 3};
        act_flags = {!(acc_done || undef || trap_valid), acc_done, undef, trap_valid};
        check(act_flags == exp_flags, req, 64'(act_flags), 64'(exp_flags));
        exp_rd = (exp == 1 && !acc_write) ? model : 64'h0;
        check(rdata == exp_rd, req, rdata, exp_rd);
        if (exp == 3)
            check(trap_el == 2'd2 && trap_class == 6'h18, "R8",
                  {56'h0, trap_el, trap_class}, {56'h0, 2'd2, 6'h18});
        @(posedge clk);
        if (exp == 1 && acc_write) model = acc_wdata;  // R10
        #1;
        check(alias_rdata == model[31:0], "R11", 64'(alias_rdata), 64'(model[31:0]));
        @(negedge clk);
    endtask

    task automatic cfg_all(input bit v);
        cfg_el2_en = v; cfg_fgt_impl = v; cfg_el3_present = v; cfg_el3_fgt_en = v;
        cfg_rd_trap = v; cfg_wr_trap = v; cfg_el0_host = 1'b0; cfg_feat64 = 1'b1;
    endtask

    task automatic acc(input logic [1:0] el, input bit wr, input logic [63:0] d,
                       input string req);
        acc_valid = 1'b1; set_enc(1'b1); cur_el = el; acc_write = wr; acc_wdata = d;
        run_access(req);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(alias_rdata == 32'h0, "R10", 64'(alias_rdata), 64'h0);
        cfg_all(1'b0);
        acc(2'd3, 1'b0, '0, "R10");
        // R7 writes at EL2/EL3 with all trap bits set
        cfg_all(1'b1);
        acc(2'd2, 1'b1, 64'hDEAD_BEEF_0123_4567, "R7");
        acc(2'd3, 1'b0, '0, "R10");
        acc(2'd3, 1'b1, 64'hFFFF_0000_A5A5_5A5A, "R7");
        acc(2'd2, 1'b0, '0, "R7");
        // R3 / R4 / R6 traps with everything set
        acc(2'd0, 1'b0, '0, "R3");
        acc(2'd1, 1'b0, '0, "R4");
        acc(2'd1, 1'b1, 64'h1111_2222_3333_4444, "R6");
        acc(2'd3, 1'b0, '0, "R9");
        // host mode lifts only the EL0 read trap
        cfg_el0_host = 1'b1;
        acc(2'd0, 1'b0, '0, "R3");
        acc(2'd1, 1'b0, '0, "R4");
        // EL3 present but its enable off lifts traps
        cfg_el0_host = 1'b0; cfg_el3_fgt_en = 1'b0;
        acc(2'd1, 1'b1, 64'h0BAD_F00D_CAFE_0001, "R6");
        acc(2'd1, 1'b0, '0, "R10");
        // EL3 absent: trap applies even without enable
        cfg_el3_present = 1'b0;
        acc(2'd1, 1'b1, 64'h7777_7777_7777_7777, "R6");
        acc(2'd0, 1'b0, '0, "R3");
        // R5 write at EL0 always undefined
        cfg_all(1'b0);
        acc(2'd0, 1'b1, 64'h9999_9999_9999_9999, "R5");
        acc(2'd0, 1'b0, '0, "R9");
        // R2 feature absent
        cfg_feat64 = 1'b0;
        acc(2'd3, 1'b1, 64'h1234_5678_9ABC_DEF0, "R2");
        acc(2'd2, 1'b0, '0, "R2");
        cfg_feat64 = 1'b1;
        acc(2'd3, 1'b0, '0, "R9");
        // R1 no match, and valid low
        acc_valid = 1'b1; set_enc(1'b0); cur_el = 2'd3; acc_write = 1'b1;
        acc_wdata = 64'h5555_AAAA_5555_AAAA;
        run_access("R1");
        acc_valid = 1'b0; set_enc(1'b1); run_access("R1");
        acc(2'd3, 1'b0, '0, "R1");
        // random sweep
        for (int i = 0; i < 600; i++) begin
            acc_valid = ($urandom_range(0, 15) != 0);
            set_enc($urandom_range(0, 5) != 0);
            cur_el = 2'($urandom_range(0, 3));
            acc_write = 1'($urandom_range(0, 1));
            acc_wdata = {$urandom(), $urandom()};
            cfg_feat64 = ($urandom_range(0, 7) != 0);
            cfg_el2_en = 1'($urandom_range(0, 1));
            cfg_el0_host = 1'($urandom_range(0, 1));
            cfg_fgt_impl = 1'($urandom_range(0, 1));
            cfg_el3_present = 1'($urandom_range(0, 1));
            cfg_el3_fgt_en = 1'($urandom_range(0, 1));
            cfg_rd_trap = 1'($urandom_range(0, 1));
            cfg_wr_trap = 1'($urandom_range(0, 1));
            run_access("R12");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule